// File: doc/BRIEF.md
# Linked-Queue Operation Engine

This block is a multi-cycle execution unit that carries out queue instructions on circular, doubly linked lists held in a 24-bit byte-addressed memory. A sentinel head node anchors each list. Every node keeps a 3-byte little-endian forward link at byte offset 0 and a 3-byte little-endian backward link at byte offset 3. An empty list is a head whose two links point back to the head itself. The engine performs four jobs as single instructions:

- insert an entry after a given node, with the entry address taken from an operand register;
- insert an entry after a given node, with the entry address read from memory through an operand pointer;
- remove the first entry after the head;
- scan the list for the first entry whose 3-byte field, at a chosen byte offset inside the entry, equals a needle value.

A sequencer pulses `start` with an opcode and three operands. The engine then holds `busy` high while it walks memory through a single byte-wide synchronous port, one access per cycle at most. It ends with a one-cycle `done` pulse, with a result address and the Z and V flags. Each 3-byte link or field is moved by a word-port submodule in three consecutive byte accesses.

The controller is a single state machine with these states:

| State | Action |
|---|---|
| `ST_IDLE` | Waits for `start`. |
| `ST_GET_ENTRY` | Reads the entry address through the pointer (indirect insert only). |
| `ST_GET_NEXT` | Reads the predecessor's forward link. |
| `ST_PUT_EFWD` | Writes the entry's forward link. |
| `ST_PUT_EBWD` | Writes the entry's backward link. |
| `ST_PUT_PFWD` | Writes the predecessor's forward link. |
| `ST_PUT_SBWD` | Writes the successor's backward link. |
| `ST_RM_FIRST` | Reads the head's forward link. |
| `ST_RM_SECOND` | Reads the victim's forward link. |
| `ST_RM_LINKH` | Relinks the head forward. |
| `ST_RM_LINKN` | Relinks the new first node backward. |
| `ST_SC_LINK` | Follows a forward link during a scan. |
| `ST_SC_FIELD` | Reads the compared field during a scan. |
| `ST_FINISH` | Raises `done` and presents the result. |

Transitions:

- `ST_IDLE` → `ST_GET_NEXT` for opcode 0.
- `ST_IDLE` → `ST_GET_ENTRY` for opcode 1, then `ST_GET_ENTRY` → `ST_GET_NEXT`.
- `ST_GET_NEXT` → `ST_PUT_EFWD` → `ST_PUT_EBWD` → `ST_PUT_PFWD` → `ST_PUT_SBWD` → `ST_FINISH`.
- `ST_IDLE` → `ST_RM_FIRST` for opcode 2.
- `ST_RM_FIRST` → `ST_FINISH` when the list is empty.
- `ST_RM_FIRST` → `ST_RM_SECOND` → `ST_RM_LINKH` → `ST_RM_LINKN` → `ST_FINISH` otherwise.
- `ST_IDLE` → `ST_SC_LINK` for opcodes 3 and 4.
- `ST_SC_LINK` → `ST_FINISH` when the walk is back at the head, or → `ST_SC_FIELD` otherwise.
- `ST_SC_FIELD` → `ST_FINISH` on a match, or → `ST_SC_LINK` otherwise.
- `ST_IDLE` → `ST_FINISH` for opcodes 5 to 7.
- `ST_FINISH` → `ST_IDLE`.

Each memory state waits for its word transfer to complete before it moves on.

Top module: `queue_engine`

## Requirements
- R1: Opcode 0 (register insert) links the entry at address B directly after node A. It writes E.fwd=S, E.bwd=A, A.fwd=E and S.bwd=E, where S is A's old forward link. The result is B, V=0, and Z=1 exactly when S equalled A (the list was empty before).
- R2: Opcode 1 (indirect insert) behaves as R1, except that the entry address is the 3-byte little-endian value stored at memory address B.
- R3: Opcode 2 (remove) with head A takes out the entry E=A.fwd. It writes A.fwd=N and N.bwd=A, where N=E.fwd. The result is E, V=0, and Z=1 exactly when N equals A (the queue has just become empty).
- R4: Opcode 2 on an already empty list writes no memory, returns A, and reports V=1 and Z=0.
- R5: Opcodes 3 and 4 (scan) walk forward from head A. They stop at the first entry whose 3-byte little-endian field at entry+offset equals the needle B, returning that entry with Z=1 and V=0. With no match, the walk returns to A and gives result A with Z=0 and V=0. A scan writes no memory.
- R6: Opcode 3 uses only C[7:0] as the field offset (0 to 255). Opcode 4 uses all 24 bits of C.
- R7: All link, field and byte addresses wrap modulo 2^24.
- R8: `busy` is high from the cycle after an accepted `start` through the `done` cycle. `done` is a single-cycle pulse. `result` and the flags change only in a `done` cycle and hold afterwards. Memory is accessed only while busy, one byte per cycle. A read returns, in the next cycle, the byte at the address presented with `mem_en`=1 and `mem_we`=0.
- R9: A `start` pulse that arrives while the engine is busy is ignored.
- R10: Opcodes 5, 6 and 7 finish with no memory access, result A, Z=0 and V=0.
- R11: After reset, `busy`, `done`, `mem_en`, `result`, Z and V are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 3 | Opcode: 0 insert, 1 indirect insert, 2 remove, 3 scan with byte offset, 4 scan with wide offset |
| opnd_a | input | 24 | Predecessor node (insert) or head node (remove, scan) |
| opnd_b | input | 24 | Entry address, entry pointer, or needle value |
| opnd_c | input | 24 | Field offset for scans |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 24 | Result address |
| flag_z | output | 1 | Z flag |
| flag_v | output | 1 | V flag |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when set, read when clear |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid one cycle after the read |

## Verification
The bench targets several corner cases, each paired with the symptom a faulty design would show:

- Insertion into an empty list is the case where the successor is the predecessor itself. A design that mishandles it leaves the head's backward link stale or reports the wrong Z.
- Removal of the last entry must raise Z. Removal from an empty list must write nothing and raise V. A design that confuses the two flags, or relinks an empty head, shows up in the flag checks and in a byte-for-byte memory comparison.
- A list placed across the top of the address space catches address arithmetic that does not wrap. A design that fails there corrupts bytes near address zero.
- A byte-offset scan with a wide operand must find the near field and not the far one. A design that ignores the opcode difference returns the wrong entry.
- Start pulses injected mid-operation must leave the running operation unchanged.

// File: rtl/qe_pkg.sv
package qe_pkg;

    localparam logic [2:0] OP_INS_REG  = 3'd0;
    localparam logic [2:0] OP_INS_IND  = 3'd1;
    localparam logic [2:0] OP_REMOVE   = 3'd2;
    localparam logic [2:0] OP_SCAN_IMM = 3'd3;
    localparam logic [2:0] OP_SCAN_REG = 3'd4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GET_ENTRY,
        ST_GET_NEXT,
        ST_PUT_EFWD,
        ST_PUT_EBWD,
        ST_PUT_PFWD,
        ST_PUT_SBWD,
        ST_RM_FIRST,
        ST_RM_SECOND,
        ST_RM_LINKH,
        ST_RM_LINKN,
        ST_SC_LINK,
        ST_SC_FIELD,
        ST_FINISH
    } qe_state_e;

endpackage

// File: rtl/qe_word_port.sv
// Moves one little-endian multi-byte word over a byte-wide synchronous port.
// Accept cycle, then one access per byte, then a completion cycle.
module qe_word_port #(
    parameter int AW     = 24,
    parameter int NBYTES = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                we,
    input  logic [AW-1:0]       addr,
    input  logic [8*NBYTES-1:0] wdata,
    output logic                done,
    output logic [8*NBYTES-1:0] rdata,
    output logic                mem_en,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [7:0]          mem_wdata,
    input  logic [7:0]          mem_rdata
);
    localparam int W   = 8 * NBYTES;
    localparam int PHW = $clog2(NBYTES + 1);
    localparam logic [PHW-1:0] LAST_PH = PHW'(NBYTES);

    logic           active_q;
    logic [PHW-1:0] ph_q;
    logic           we_q;
    logic [AW-1:0]  addr_q;
    logic [W-1:0]   wdata_q;
    logic [W-1:0]   rbuf_q;
    logic [W-1:0]   wshift;
    logic           access;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            ph_q     <= '0;
            we_q     <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            rbuf_q   <= '0;
        end else if (!active_q) begin
            if (req) begin
                active_q <= 1'b1;
                ph_q     <= '0;
                we_q     <= we;
                addr_q   <= addr;
                wdata_q  <= wdata;
            end
        end else begin
            if (ph_q == LAST_PH) begin
                active_q <= 1'b0;
            end else begin
                ph_q <= ph_q + 1'b1;
            end
            if (ph_q != '0 && !we_q) begin
                rbuf_q <= {mem_rdata, rbuf_q[W-1:8]};
            end
        end
    end

    always_comb begin
        access    = active_q && (ph_q < LAST_PH);
        wshift    = wdata_q >> {ph_q, 3'b000};
        mem_en    = access;
        mem_we    = access && we_q;
        mem_addr  = addr_q + AW'(ph_q);
        mem_wdata = wshift[7:0];
        done      = active_q && (ph_q == LAST_PH);
        rdata     = {mem_rdata, rbuf_q[W-1:8]};
    end

endmodule

// File: rtl/qe_ctrl.sv
// Instruction sequencer for insert, remove and scan on circular linked lists.
module qe_ctrl
    import qe_pkg::*;
#(
    parameter int AW    = 24,
    parameter int IMM_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic [AW-1:0] opnd_a,
    input  logic [AW-1:0] opnd_b,
    input  logic [AW-1:0] opnd_c,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] result,
    output logic          flag_z,
    output logic          flag_v,
    output logic          wp_req,
    output logic          wp_we,
    output logic [AW-1:0] wp_addr,
    output logic [AW-1:0] wp_wdata,
    input  logic          wp_done,
    input  logic [AW-1:0] wp_rdata
);
    localparam int LINK_BYTES = AW / 8;
    localparam logic [AW-1:0] BWD_OFS = AW'(LINK_BYTES);

    qe_state_e     state_q, state_d;
    logic [AW-1:0] head_q, key_q, off_q, ent_q, nbr_q, cur_q;
    logic [AW-1:0] res_q, res_d;
    logic          z_q, z_d, v_q, v_d;
    logic          accept, ent_ld, nbr_ld, cur_ld, fin;

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            head_q  <= '0;
            key_q   <= '0;
            off_q   <= '0;
            ent_q   <= '0;
            nbr_q   <= '0;
            cur_q   <= '0;
            res_q   <= '0;
            z_q     <= 1'b0;
            v_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                head_q <= opnd_a;
                key_q  <= opnd_b;
                ent_q  <= opnd_b;
                cur_q  <= opnd_a;
                off_q  <= (op == OP_SCAN_IMM) ? {{(AW-IMM_W){1'b0}}, opnd_c[IMM_W-1:0]}
                                              : opnd_c;
            end
            if (ent_ld) ent_q <= wp_rdata;
            if (nbr_ld) nbr_q <= wp_rdata;
            if (cur_ld) cur_q <= ent_q;
            if (fin) begin
                res_q <= res_d;
                z_q   <= z_d;
                v_q   <= v_d;
            end
        end
    end

    // next state, memory requests and result selection
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        ent_ld   = 1'b0;
        nbr_ld   = 1'b0;
        cur_ld   = 1'b0;
        fin      = 1'b0;
        res_d    = head_q;
        z_d      = 1'b0;
        v_d      = 1'b0;
        wp_req   = 1'b0;
        wp_we    = 1'b0;
        wp_addr  = '0;
        wp_wdata = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    accept = 1'b1;
                    case (op)
                        OP_INS_REG:  state_d = ST_GET_NEXT;
                        OP_INS_IND:  state_d = ST_GET_ENTRY;
                        OP_REMOVE:   state_d = ST_RM_FIRST;
                        OP_SCAN_IMM,
                        OP_SCAN_REG: state_d = ST_SC_LINK;
                        default: begin
                            state_d = ST_FINISH;
                            fin     = 1'b1;
                            res_d   = opnd_a;
                        end
                    endcase
                end
            end
            ST_GET_ENTRY: begin
                wp_req  = 1'b1;
                wp_addr = key_q;
                if (wp_done) begin
                    ent_ld  = 1'b1;
                    state_d = ST_GET_NEXT;
                end
            end
            ST_GET_NEXT: begin
                wp_req  = 1'b1;
                wp_addr = head_q;
                if (wp_done) begin
                    nbr_ld  = 1'b1;
                    state_d = ST_PUT_EFWD;
                end
            end
            ST_PUT_EFWD: begin
                wp_req   = 1'b1;
                wp_we    = 1'b1;
                wp_addr  = ent_q;
                wp_wdata = nbr_q;
                if (wp_done) state_d = ST_PUT_EBWD;
            end
            ST_PUT_EBWD: begin
                wp_req   = 1'b1;
                wp_we    = 1'b1;
                wp_addr  = ent_q + BWD_OFS;
                wp_wdata = head_q;
                if (wp_done) state_d = ST_PUT_PFWD;
            end
            ST_PUT_PFWD: begin
                wp_req   = 1'b1;
                wp_we    = 1'b1;
                wp_addr  = head_q;
                wp_wdata = ent_q;
                if (wp_done) state_d = ST_PUT_SBWD;
            end
            ST_PUT_SBWD: begin
                wp_req   = 1'b1;
                wp_we    = 1'b1;
                wp_addr  = nbr_q + BWD_OFS;
                wp_wdata = ent_q;
                if (wp_done) begin
                    fin     = 1'b1;
                    res_d   = ent_q;
                    z_d     = (nbr_q == head_q);
                    state_d = ST_FINISH;
                end
            end
            ST_RM_FIRST: begin
                wp_req  = 1'b1;
                wp_addr = head_q;
                if (wp_done) begin
                    if (wp_rdata == head_q) begin
                        fin     = 1'b1;
                        v_d     = 1'b1;
                        state_d = ST_FINISH;
                    end else begin
                        ent_ld  = 1'b1;
                        state_d = ST_RM_SECOND;
                    end
                end
            end
            ST_RM_SECOND: begin
                wp_req  = 1'b1;
                wp_addr = ent_q;
                if (wp_done) begin
                    nbr_ld  = 1'b1;
                    state_d = ST_RM_LINKH;
                end
            end
            ST_RM_LINKH: begin
                wp_req   = 1'b1;
                wp_we    = 1'b1;
                wp_addr  = head_q;
                wp_wdata = nbr_q;
                if (wp_done) state_d = ST_RM_LINKN;
            end
            ST_RM_LINKN: begin
                wp_req   = 1'b1;
                wp_we    = 1'b1;
                wp_addr  = nbr_q + BWD_OFS;
                wp_wdata = head_q;
                if (wp_done) begin
                    fin     = 1'b1;
                    res_d   = ent_q;
                    z_d     = (nbr_q == head_q);
                    state_d = ST_FINISH;
                end
            end
            ST_SC_LINK: begin
                wp_req  = 1'b1;
                wp_addr = cur_q;
                if (wp_done) begin
                    if (wp_rdata == head_q) begin
                        fin     = 1'b1;
                        state_d = ST_FINISH;
                    end else begin
                        ent_ld  = 1'b1;
                        state_d = ST_SC_FIELD;
                    end
                end
            end
            ST_SC_FIELD: begin
                wp_req  = 1'b1;
                wp_addr = ent_q + off_q;
                if (wp_done) begin
                    if (wp_rdata == key_q) begin
                        fin     = 1'b1;
                        res_d   = ent_q;
                        z_d     = 1'b1;
                        state_d = ST_FINISH;
                    end else begin
                        cur_ld  = 1'b1;
                        state_d = ST_SC_LINK;
                    end
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign busy   = (state_q != ST_IDLE);
    assign done   = (state_q == ST_FINISH);
    assign result = res_q;
    assign flag_z = z_q;
    assign flag_v = v_q;

endmodule

// File: rtl/queue_engine.sv
module queue_engine #(
    parameter int ADDR_W = 24,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [ADDR_W-1:0] opnd_a,
    input  logic [ADDR_W-1:0] opnd_b,
    input  logic [ADDR_W-1:0] opnd_c,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] result,
    output logic              flag_z,
    output logic              flag_v,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    localparam int LINK_BYTES = ADDR_W / 8;

    logic              wp_req, wp_we, wp_done;
    logic [ADDR_W-1:0] wp_addr, wp_wdata, wp_rdata;

    qe_ctrl #(.AW(ADDR_W), .IMM_W(IMM_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op       (op),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .opnd_c   (opnd_c),
        .busy     (busy),
        .done     (done),
        .result   (result),
        .flag_z   (flag_z),
        .flag_v   (flag_v),
        .wp_req   (wp_req),
        .wp_we    (wp_we),
        .wp_addr  (wp_addr),
        .wp_wdata (wp_wdata),
        .wp_done  (wp_done),
        .wp_rdata (wp_rdata)
    );

    qe_word_port #(.AW(ADDR_W), .NBYTES(LINK_BYTES)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (wp_req),
        .we        (wp_we),
        .addr      (wp_addr),
        .wdata     (wp_wdata),
        .done      (wp_done),
        .rdata     (wp_rdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

endmodule

// File: rtl/queue_engine_chk.sv
module queue_engine_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] result,
    input logic              flag_z,
    input logic              flag_v,
    input logic              mem_en,
    input logic              mem_we
);
    assert_mem_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> busy);

    assert_write_is_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

    assert_done_inside_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_until_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_result_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({flag_z, flag_v}) |-> done);

    assert_empty_remove_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_v) |-> !flag_z);

endmodule

bind queue_engine queue_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .result (result),
    .flag_z (flag_z),
    .flag_v (flag_v),
    .mem_en (mem_en),
    .mem_we (mem_we)
);

// File: tb/sim_queue_engine.sv
`timescale 1ns/1ps
module sim_queue_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [23:0] opnd_a = '0, opnd_b = '0, opnd_c = '0;
    logic        busy, done, flag_z, flag_v, mem_en, mem_we;
    logic [23:0] result, mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    always #5 clk = ~clk;

    queue_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .busy(busy), .done(done), .result(result),
        .flag_z(flag_z), .flag_v(flag_v),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    logic [7:0] dmem [int unsigned];
    logic [7:0] rmem [int unsigned];
    int unsigned acc_cnt = 0, wr_cnt = 0;
    int total = 0, bad = 0;
    int unsigned last_acc, last_wr;
    bit reported = 0;

    always @(posedge clk) begin
        if (mem_en) begin
            acc_cnt++;
            if (mem_we) begin
                wr_cnt++;
                dmem[{8'h00, mem_addr}] = mem_wdata;
            end else begin
                mem_rdata <= dmem.exists({8'h00, mem_addr}) ? dmem[{8'h00, mem_addr}] : 8'h00;
            end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] rpeek(input int unsigned k);
        return rmem.exists(k) ? rmem[k] : 8'h00;
    endfunction
    function automatic logic [7:0] dpeek(input int unsigned k);
        return dmem.exists(k) ? dmem[k] : 8'h00;
    endfunction
    function automatic logic [23:0] rd24(input logic [23:0] a);
        logic [23:0] v;
        for (int k = 0; k < 3; k++) begin
            logic [23:0] ak;
            ak = a + 24'(k);
            v[8*k +: 8] = rpeek({8'h00, ak});
        end
        return v;
    endfunction
    task automatic put24(input logic [23:0] a, input logic [23:0] v, input bit both);
        for (int k = 0; k < 3; k++) begin
            logic [23:0] ak;
            ak = a + 24'(k);
            rmem[{8'h00, ak}] = v[8*k +: 8];
            if (both) dmem[{8'h00, ak}] = v[8*k +: 8];
        end
    endtask

    // reference behaviour computed from the requirements
    task automatic model_ins(input logic [23:0] p, input logic [23:0] e,
                             output logic [23:0] r, output bit z, output bit v);
        logic [23:0] s;
        s = rd24(p);
        put24(e, s, 0);
        put24(e + 24'd3, p, 0);
        put24(p, e, 0);
        put24(s + 24'd3, e, 0);
        r = e; z = (s == p); v = 0;
    endtask
    task automatic model_rem(input logic [23:0] h, output logic [23:0] r, output bit z, output bit v);
        logic [23:0] e, n;
        e = rd24(h);
        if (e == h) begin
            r = h; z = 0; v = 1;
        end else begin
            n = rd24(e);
            put24(h, n, 0);
            put24(n + 24'd3, h, 0);
            r = e; z = (n == h); v = 0;
        end
    endtask
    task automatic model_scan(input logic [23:0] h, input logic [23:0] key, input logic [23:0] off,
                              output logic [23:0] r, output bit z, output bit v);
        logic [23:0] cur, nx;
        cur = h; r = h; z = 0; v = 0;
        for (int i = 0; i < 64; i++) begin
            nx = rd24(cur);
            if (nx == h) break;
            if (rd24(nx + off) == key) begin
                r = nx; z = 1;
                break;
            end
            cur = nx;
        end
    endtask
    task automatic expect_op(input logic [2:0] o, input logic [23:0] a, input logic [23:0] b,
                             input logic [23:0] c, output logic [23:0] r, output bit z, output bit v);
        case (o)
            3'd0: model_ins(a, b, r, z, v);
            3'd1: model_ins(a, rd24(b), r, z, v);
            3'd2: model_rem(a, r, z, v);
            3'd3: model_scan(a, b, {16'h0000, c[7:0]}, r, z, v);
            3'd4: model_scan(a, b, c, r, z, v);
            default: begin r = a; z = 0; v = 0; end
        endcase
    endtask

    task automatic mem_match(input string what);
        bit ok = 1;
        int unsigned where = 0;
        foreach (dmem[k]) if (dmem[k] !== rpeek(k)) begin ok = 0; where = k; end
        foreach (rmem[k]) if (rmem[k] !== dpeek(k)) begin ok = 0; where = k; end
        chk(ok, {what, " memory image"}, dpeek(where), rpeek(where));
    endtask

    task automatic run_op(input logic [2:0] o, input logic [23:0] a, input logic [23:0] b,
                          input logic [23:0] c, input bit glitch, input string tag,
                          output logic [23:0] r_out);
        logic [23:0] er;
        bit ez, ev, busy_ok;
        int unsigned a0, w0;
        int cyc;
        expect_op(o, a, b, c, er, ez, ev);
        @(negedge clk);
        op = o; opnd_a = a; opnd_b = b; opnd_c = c; start = 1;
        a0 = acc_cnt; w0 = wr_cnt;
        @(negedge clk);
        start = 0;
        busy_ok = busy;
        cyc = 0;
        while (!done && cyc < 4000) begin
            if (!busy) busy_ok = 0;
            if (glitch && cyc == 2) begin
                start = 1; op = 3'd2; opnd_a = 24'h000100; opnd_b = 24'h0; opnd_c = 24'h0;
            end else begin
                start = 0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 0;
        if (cyc >= 4000) chk(0, {tag, " R8 watchdog per operation"}, 32'(cyc), 32'd4000);
        chk(busy_ok && busy, {tag, " R8 busy through operation"}, {31'd0, busy}, 32'd1);
        chk(result === er, {tag, " result"}, {8'h0, result}, {8'h0, er});
        chk(flag_z === ez && flag_v === ev, {tag, " flags Z,V"}, {30'd0, flag_z, flag_v}, {30'd0, ez, ev});
        mem_match(tag);
        last_acc = acc_cnt - a0;
        last_wr  = wr_cnt - w0;
        r_out = er;
    endtask

    initial begin
        #2000000;
        if (!reported) begin
            reported = 1;
            bad++; total++;
            $display("FAIL R8 global watchdog actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [23:0] H1  = 24'h000100;
    localparam logic [23:0] H2  = 24'h000300;
    localparam logic [23:0] E1  = 24'h000400;
    localparam logic [23:0] E2  = 24'h000500;
    localparam logic [23:0] E3  = 24'h000600;
    localparam logic [23:0] PTR = 24'h000800;
    localparam logic [23:0] HW  = 24'hFFFFFE;
    localparam logic [23:0] EW  = 24'hFFFFF8;
    localparam logic [23:0] EB  = 24'h001000;
    localparam int NE = 12;

    initial begin
        logic [23:0] r;
        logic [23:0] held;
        bit in_q [NE];
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!busy && !done && !mem_en, "R11 idle outputs after reset", {29'd0, busy, done, mem_en}, 32'd0);
        chk(result == 0 && !flag_z && !flag_v, "R11 result and flags after reset",
            {6'd0, result, flag_z, flag_v}, 32'd0);
        @(negedge clk);
        rst_n = 1;

        put24(H1, H1, 1); put24(H1 + 24'd3, H1, 1);
        put24(H2, H2, 1); put24(H2 + 24'd3, H2, 1);

        run_op(3'd2, H1, 0, 0, 0, "R4 remove on empty", r);
        chk(last_wr == 0, "R4 no write on empty remove", last_wr, 0);
        run_op(3'd4, H1, 24'h000000, 24'd10, 0, "R5 scan of empty list", r);
        chk(last_wr == 0, "R5 scan writes nothing", last_wr, 0);

        run_op(3'd0, H1, E1, 0, 0, "R1 insert into empty", r);
        run_op(3'd0, H1, E2, 0, 1, "R9 insert with start while busy", r);
        put24(PTR, E3, 1);
        run_op(3'd1, E1, PTR, 0, 0, "R2 indirect insert", r);

        put24(E1 + 24'h10, 24'h123456, 1);
        put24(E1 + 24'h110, 24'h654321, 1);
        run_op(3'd3, H1, 24'h123456, 24'h000110, 0, "R6 byte offset scan match", r);
        run_op(3'd4, H1, 24'h123456, 24'h000110, 0, "R6 wide offset scan no match", r);
        run_op(3'd4, H1, 24'h654321, 24'h000110, 0, "R5 wide offset scan match", r);
        chk(last_wr == 0, "R5 matching scan writes nothing", last_wr, 0);

        // R7 list across the top of the address space
        put24(HW, HW, 1); put24(HW + 24'd3, HW, 1);
        put24(EW + 24'h20, 24'hABCDEF, 1);
        run_op(3'd0, HW, EW, 0, 0, "R7 insert at wrapped head", r);
        run_op(3'd4, HW, 24'hABCDEF, 24'h20, 0, "R7 scan field across wrap", r);
        run_op(3'd2, HW, 0, 0, 0, "R7 remove at wrapped head", r);

        run_op(3'd6, 24'h000123, 24'h7, 24'h9, 0, "R10 reserved opcode", r);
        chk(last_acc == 0, "R10 reserved opcode touches no memory", last_acc, 0);
        held = result;
        repeat (3) @(negedge clk);
        chk(result == held && !busy, "R8 result held after done", {8'h0, result}, {8'h0, held});

        run_op(3'd2, H1, 0, 0, 0, "R3 remove first", r);
        run_op(3'd2, H1, 0, 0, 1, "R3 remove second", r);
        run_op(3'd2, H1, 0, 0, 0, "R3 remove last sets Z", r);
        run_op(3'd2, H1, 0, 0, 0, "R4 remove after drain", r);
        chk(last_wr == 0, "R4 drained list unwritten", last_wr, 0);

        // constrained random traffic on a second list
        for (int k = 0; k < NE; k++) begin
            in_q[k] = 0;
            for (int j = 6; j < 300; j++) begin
                logic [23:0] ba;
                ba = EB + 24'(k * 512 + j);
                rmem[{8'h00, ba}] = 8'($urandom % 4);
                dmem[{8'h00, ba}] = rmem[{8'h00, ba}];
            end
        end
        for (int it = 0; it < 160; it++) begin
            int sel, fk, mk;
            bit gl;
            logic [23:0] c, off, key, pred;
            sel = int'($urandom % 100);
            gl  = ($urandom % 5) == 0;
            fk = -1;
            for (int s = 0; s < NE; s++) begin
                int i;
                i = (s + int'($urandom % NE)) % NE;
                if (!in_q[i] && fk < 0) fk = i;
            end
            mk = int'($urandom % NE);
            if (sel < 40 && fk >= 0) begin
                pred = (in_q[mk] && ($urandom % 2 == 1)) ? EB + 24'(mk * 512) : H2;
                if ($urandom % 2 == 1) begin
                    run_op(3'd0, pred, EB + 24'(fk * 512), 0, gl, "R1 random insert", r);
                end else begin
                    put24(PTR, EB + 24'(fk * 512), 1);
                    run_op(3'd1, pred, PTR, 0, gl, "R2 random indirect insert", r);
                end
                in_q[fk] = 1;
            end else if (sel < 65) begin
                run_op(3'd2, H2, 0, 0, gl, "R3 random remove", r);
                if (r != H2) in_q[(r - EB) / 512] = 0;
            end else begin
                if ($urandom % 2 == 1) begin
                    c = 24'($urandom);
                    off = {16'h0, c[7:0]};
                end else begin
                    c = 24'(6 + $urandom % 290);
                    off = c;
                end
                key = ($urandom % 4 == 0) ? 24'($urandom) : rd24(EB + 24'(mk * 512) + off);
                if (c[8] && c > 24'd300) run_op(3'd3, H2, key, c, gl, "R6 random byte offset scan", r);
                else if (off == c)       run_op(3'd4, H2, key, c, gl, "R5 random wide offset scan", r);
                else                     run_op(3'd3, H2, key, c, gl, "R6 random byte offset scan", r);
            end
        end

        if (!reported) begin
            reported = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule